// File: doc/BRIEF.md
# Context-Indexed Token Histogram Engine

The engine counts entropy-coding tokens. It keeps one frequency histogram per context, and each histogram has a fixed number of value bins. Tokens arrive one per cycle as 64-bit words on a valid/ready stream. Each word carries a value, a context index and a flag that marks an LZ77 length. The engine splits the word and adds one to the bin that the context and value select. The bin counters live in a single RAM and are updated by read-modify-write. A one-deep forwarding path covers repeated hits on the same bin, so the token rate does not drop when tokens repeat. The engine also keeps three counters:

- the number of tokens counted in the histogram;
- the number of tokens that were out of range;
- the number of tokens that carried the LZ77 flag.

A pulse on `start` begins a pass. The engine first sweeps the RAM to zero, one bin per cycle, and holds `ready` low while it does so. It then accepts tokens until one arrives with `s_last` set. After that it emits, in ascending order, the index of every context that received a token, and then raises `done`. While `done` is high, the host reads any bin through a one-cycle read port, together with the three counters.

Each token layer gets its own instance. The instances share no state and run side by side. A layer enable is sampled at `start`. When it is low, the pass clears everything and reaches `done` without ever accepting a token.

Top module: `tok_hist_engine`

## Requirements
- R1: A token word is decoded as value = bits [31:0], context = bits [62:32], LZ77 flag = bit 63. After a pass, the bin for (c, v) holds the number of accepted in-range tokens with context c and value v. The read port addresses it by `rd_ctx` = c and `rd_val` = v.
- R2: The engine accepts tokens on consecutive cycles, including runs and alternations that hit the same bin, and loses no increment.
- R3: A `start` accepted in idle or done clears every bin, the non-empty record and all counters. `s_ready` stays low for exactly NUM_CTX*NUM_VAL cycles after the start edge. No count from an earlier pass remains.
- R4: A token is out of range when its context is at least NUM_CTX or its value is at least NUM_VAL. Such a token adds one to `ovf_cnt`. It changes no bin, does not add to `total_cnt` and does not mark its context as non-empty.
- R5: `total_cnt` equals the number of accepted in-range tokens in the pass.
- R6: `lz_cnt` equals the number of accepted tokens that have bit 63 set, whether in range or not. The flag has no effect on which bin a token updates.
- R7: After the last token, the engine lists exactly the contexts that received at least one in-range token. It shows one index per `ne_valid` cycle, in strictly ascending order, and then holds `done` high. The counters stay stable until the next `start`.
- R8: When `layer_en` is low at `start`, `s_ready` never rises during the pass. The list is empty, all bins and counters read zero, and `done` still rises.
- R9: When `rd_en` is high with `done`, `rd_valid` and the bin count appear on the next cycle. `rd_en` while `done` is low gives no `rd_valid`.
- R10: Once a token with `s_last` is accepted, `s_ready` falls on the next cycle. Tokens offered after that point are not counted.
- R11: After reset, `s_ready`, `done`, `ne_valid` and `rd_valid` are low and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| layer_en | input | 1 | Layer enable, sampled with `start` |
| start | input | 1 | Begin a pass (honoured in idle or done) |
| s_valid | input | 1 | Token valid |
| s_ready | output | 1 | Token accepted when high with `s_valid` |
| s_token | input | 64 | Packed token word |
| s_last | input | 1 | Marks the final token of the stream |
| rd_en | input | 1 | Bin read request (effective while `done`) |
| rd_ctx | input | $clog2(NUM_CTX) | Context of the bin to read |
| rd_val | input | $clog2(NUM_VAL) | Value of the bin to read |
| rd_valid | output | 1 | `rd_data` holds the requested count |
| rd_data | output | CNT_W | Bin count |
| ne_valid | output | 1 | `ne_ctx` is a non-empty context |
| ne_ctx | output | $clog2(NUM_CTX) | Non-empty context index |
| done | output | 1 | Pass complete, results readable |
| total_cnt | output | CNT_W | Tokens counted in the histogram |
| ovf_cnt | output | CNT_W | Out-of-range tokens |
| lz_cnt | output | CNT_W | Tokens with the LZ77 flag |

## Verification
The assertions assume that `start` is only pulsed while the engine is idle or done, and that `rd_ctx`/`rd_val` stay inside the configured ranges. The bench pulses `start` only after `done` and reads only valid coordinates. The assertions also assume that no counter wraps within a pass. Every pass in the bench is far shorter than the counter range, so they never do. The bench keeps `s_valid` high through the clear, flush and list phases and through a disabled pass, so that any wrongly accepted token would show up in the counters.

// File: rtl/tok_hist_pkg.sv
// Shared types for the token histogram engine.
// Assumes: token words are 64 bits with the flag in the top bit.
package tok_hist_pkg;

    localparam int TOKEN_W = 64;

    // Packed token layout: flag at bit 63, context in 62:32, value in 31:0.
    typedef struct packed {
        logic        lz;
        logic [30:0] ctx;
        logic [31:0] val;
    } token_t;

    // Pass sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RUN,
        ST_FLUSH,
        ST_LIST,
        ST_DONE
    } eng_state_t;

endpackage

// File: rtl/tok_hist_decode.sv
// Splits a token word into its fields, checks it against the configured
// histogram shape, and forms the flat bin address ctx*NUM_VAL+val.
// Assumes: NUM_CTX and NUM_VAL are at least 2.
module tok_hist_decode
    import tok_hist_pkg::*;
#(
    parameter int NUM_CTX = 16,
    parameter int NUM_VAL = 8,
    localparam int CTX_AW = $clog2(NUM_CTX),
    localparam int VAL_AW = $clog2(NUM_VAL),
    localparam int BIN_AW = $clog2(NUM_CTX * NUM_VAL)
) (
    input  logic [TOKEN_W-1:0] tok_word,
    output logic               in_range,
    output logic               lz_flag,
    output logic [CTX_AW-1:0]  ctx_idx,
    output logic [BIN_AW-1:0]  bin_addr
);

    token_t             tok;
    logic [VAL_AW-1:0]  val_idx;

    assign tok = token_t'(tok_word);

    // Field extraction and range test.
    always_comb begin
        lz_flag  = tok.lz;
        ctx_idx  = tok.ctx[CTX_AW-1:0];
        val_idx  = tok.val[VAL_AW-1:0];
        in_range = ({1'b0, tok.ctx} < 32'(NUM_CTX)) && (tok.val < 32'(NUM_VAL));
        bin_addr = BIN_AW'(ctx_idx) * BIN_AW'(NUM_VAL) + BIN_AW'(val_idx);
    end

endmodule

// File: rtl/tok_hist_bank.sv
// Counter RAM with a one-stage read-modify-write increment pipeline.
// A registered copy of the last write is forwarded when the next increment
// targets the same bin, so a read that raced that write is corrected.
// The clear sweep and the host read share the same ports.
// Assumes: clear writes and increments never occur in the same cycle.
module tok_hist_bank #(
    parameter int NUM_BINS = 128,
    parameter int CNT_W    = 32,
    localparam int BIN_AW  = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [BIN_AW-1:0] clr_addr,
    input  logic              inc_req,
    input  logic [BIN_AW-1:0] inc_addr,
    input  logic [BIN_AW-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0]  mem [NUM_BINS];
    logic [CNT_W-1:0]  rdata_q;
    logic [BIN_AW-1:0] raddr;
    logic              s1_v;
    logic [BIN_AW-1:0] s1_addr;
    logic              fw_v;
    logic [BIN_AW-1:0] fw_addr;
    logic [CNT_W-1:0]  fw_data;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  upd;

    // The token path owns the read port while counting; otherwise the host.
    assign raddr = inc_req ? inc_addr : rd_addr;

    // Synchronous RAM read.
    always_ff @(posedge clk) begin
        rdata_q <= mem[raddr];
    end

    // Increment stage and forwarding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_addr <= '0;
            fw_v    <= 1'b0;
            fw_addr <= '0;
            fw_data <= '0;
        end else begin
            s1_v    <= inc_req;
            s1_addr <= inc_addr;
            fw_v    <= s1_v;
            fw_addr <= s1_addr;
            fw_data <= upd;
        end
    end

    // Pick the freshest copy of the bin and add one.
    always_comb begin
        base = (fw_v && (fw_addr == s1_addr)) ? fw_data : rdata_q;
        upd  = base + CNT_ONE;
    end

    // Single RAM write port: clear sweep or increment.
    always_ff @(posedge clk) begin
        if (clr_we) begin
            mem[clr_addr] <= '0;
        end else if (s1_v) begin
            mem[s1_addr] <= upd;
        end
    end

    assign rd_data = rdata_q;

    // R3: the clear sweep never collides with a pending increment.
    a_r3_clear_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_we && s1_v));

    // R2: a forwarded increment always produces a larger count than it read.
    a_r2_fwd_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && fw_v && (fw_addr == s1_addr)) |=> (fw_data > $past(fw_data)));

endmodule

// File: rtl/tok_hist_ctxlist.sv
// Keeps one sticky flag per context. The flags are cleared at pass start
// and set by counted tokens. During the list phase a scan emits the
// flagged indices in ascending order, one index position per cycle.
// Assumes: clr and scan_en are never high together.
module tok_hist_ctxlist #(
    parameter int NUM_CTX = 16,
    localparam int CTX_AW = $clog2(NUM_CTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [CTX_AW-1:0] set_ctx,
    input  logic              scan_en,
    output logic              ne_valid,
    output logic [CTX_AW-1:0] ne_ctx,
    output logic              scan_last
);

    localparam logic [CTX_AW-1:0] LAST_IDX = CTX_AW'(NUM_CTX - 1);

    logic [NUM_CTX-1:0] flags;
    logic [CTX_AW-1:0]  scan_idx;

    // Sticky non-empty flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '0;
        end else if (set_en) begin
            flags[set_ctx] <= 1'b1;
        end
    end

    // Ascending scan pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            scan_idx <= '0;
        end else if (scan_en && !scan_last) begin
            scan_idx <= scan_idx + CTX_AW'(1);
        end
    end

    assign scan_last = (scan_idx == LAST_IDX);
    assign ne_valid  = scan_en && flags[scan_idx];
    assign ne_ctx    = scan_idx;

    // R7: emitted indices strictly ascend.
    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        ne_valid |=> (!ne_valid || (ne_ctx > $past(ne_ctx))));

    // R7: a flag, once set, survives until the next clear.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/tok_hist_engine.sv
// Per-layer token histogram engine. It sequences a pass through clear,
// counting, flush, non-empty listing and done. It keeps the total,
// out-of-range and LZ77-flag counters and gates host bin reads to done.
// Assumes: start is pulsed only while idle or done; rd_ctx/rd_val in range.
module tok_hist_engine
    import tok_hist_pkg::*;
#(
    parameter int NUM_CTX = 16,
    parameter int NUM_VAL = 8,
    parameter int CNT_W   = 32,
    localparam int CTX_AW   = $clog2(NUM_CTX),
    localparam int VAL_AW   = $clog2(NUM_VAL),
    localparam int NUM_BINS = NUM_CTX * NUM_VAL,
    localparam int BIN_AW   = $clog2(NUM_BINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               layer_en,
    input  logic               start,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [TOKEN_W-1:0] s_token,
    input  logic               s_last,
    input  logic               rd_en,
    input  logic [CTX_AW-1:0]  rd_ctx,
    input  logic [VAL_AW-1:0]  rd_val,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data,
    output logic               ne_valid,
    output logic [CTX_AW-1:0]  ne_ctx,
    output logic               done,
    output logic [CNT_W-1:0]   total_cnt,
    output logic [CNT_W-1:0]   ovf_cnt,
    output logic [CNT_W-1:0]   lz_cnt
);

    localparam logic [BIN_AW-1:0] LAST_BIN = BIN_AW'(NUM_BINS - 1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    eng_state_t        state;
    logic [BIN_AW-1:0] clr_addr;
    logic              en_q;
    logic              start_ok;
    logic              accept;
    logic              tok_in_range;
    logic              tok_lz;
    logic [CTX_AW-1:0] tok_ctx;
    logic [BIN_AW-1:0] tok_bin;
    logic [BIN_AW-1:0] rd_addr;
    logic              rd_req;
    logic              scan_last;

    assign start_ok = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign s_ready  = (state == ST_RUN);
    assign accept   = s_valid && s_ready;
    assign done     = (state == ST_DONE);
    assign rd_req   = rd_en && done;
    assign rd_addr  = BIN_AW'(rd_ctx) * BIN_AW'(NUM_VAL) + BIN_AW'(rd_val);

    tok_hist_decode #(
        .NUM_CTX (NUM_CTX),
        .NUM_VAL (NUM_VAL)
    ) u_decode (
        .tok_word (s_token),
        .in_range (tok_in_range),
        .lz_flag  (tok_lz),
        .ctx_idx  (tok_ctx),
        .bin_addr (tok_bin)
    );

    tok_hist_bank #(
        .NUM_BINS (NUM_BINS),
        .CNT_W    (CNT_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (state == ST_CLEAR),
        .clr_addr (clr_addr),
        .inc_req  (accept && tok_in_range),
        .inc_addr (tok_bin),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    tok_hist_ctxlist #(
        .NUM_CTX (NUM_CTX)
    ) u_ctxlist (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_ok),
        .set_en    (accept && tok_in_range),
        .set_ctx   (tok_ctx),
        .scan_en   (state == ST_LIST),
        .ne_valid  (ne_valid),
        .ne_ctx    (ne_ctx),
        .scan_last (scan_last)
    );

    // Pass sequencer and clear-sweep address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            clr_addr <= '0;
            en_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        state    <= ST_CLEAR;
                        clr_addr <= '0;
                        en_q     <= layer_en;
                    end
                end
                ST_CLEAR: begin
                    clr_addr <= clr_addr + BIN_AW'(1);
                    if (clr_addr == LAST_BIN) begin
                        state <= en_q ? ST_RUN : ST_LIST;
                    end
                end
                ST_RUN: begin
                    if (accept && s_last) begin
                        state <= ST_FLUSH;
                    end
                end
                ST_FLUSH: begin
                    state <= ST_LIST;
                end
                ST_LIST: begin
                    if (scan_last) begin
                        state <= ST_DONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Pass counters: in-range total, out-of-range, LZ77-flagged.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            total_cnt <= '0;
            ovf_cnt   <= '0;
            lz_cnt    <= '0;
        end else if (accept) begin
            if (tok_in_range) begin
                total_cnt <= total_cnt + CNT_ONE;
            end else begin
                ovf_cnt <= ovf_cnt + CNT_ONE;
            end
            if (tok_lz) begin
                lz_cnt <= lz_cnt + CNT_ONE;
            end
        end
    end

    // Host read response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
        end
    end

    // R3: no token is accepted in the cycle after a start.
    a_r3_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !s_ready);

    // R5: the total never decreases while counting.
    a_r5_total_nondecr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (total_cnt >= $past(total_cnt)));

    // R8: a disabled layer never offers ready.
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !s_ready);

    // R10: ready drops after the last token.
    a_r10_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> !s_ready);

    // R9: reads outside done give no response.
    a_r9_rd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done) |=> !rd_valid);

    // R7: results hold while done and no new pass starts.
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(total_cnt) && $stable(ovf_cnt) && $stable(lz_cnt)));

endmodule

// File: tb/test_tok_hist_engine.sv
`timescale 1ns/1ps
module test_tok_hist_engine;

    localparam int NC = 4;
    localparam int NV = 4;
    localparam int NB = NC * NV;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          layer_en = 1'b0;
    logic          start = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [63:0]   s_token = '0;
    logic          s_last = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_ctx = '0;
    logic [1:0]    rd_val = '0;
    logic          rd_valid;
    logic [CW-1:0] rd_data;
    logic          ne_valid;
    logic [1:0]    ne_ctx;
    logic          done;
    logic [CW-1:0] total_cnt;
    logic [CW-1:0] ovf_cnt;
    logic [CW-1:0] lz_cnt;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    int exp_bin[NB];
    int exp_total, exp_ovf, exp_lz;
    int got_list[NB];
    int got_n;

    always #2 clk = ~clk;

    tok_hist_engine #(.NUM_CTX(NC), .NUM_VAL(NV), .CNT_W(CW)) i_tok_hist_engine (
        .clk(clk), .rst_n(rst_n), .layer_en(layer_en), .start(start),
        .s_valid(s_valid), .s_ready(s_ready), .s_token(s_token), .s_last(s_last),
        .rd_en(rd_en), .rd_ctx(rd_ctx), .rd_val(rd_val), .rd_valid(rd_valid),
        .rd_data(rd_data), .ne_valid(ne_valid), .ne_ctx(ne_ctx), .done(done),
        .total_cnt(total_cnt), .ovf_cnt(ovf_cnt), .lz_cnt(lz_cnt)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Start a pass; for an enabled layer count the cycles ready stays low (R3).
    task automatic begin_pass(input bit en);
        for (int b = 0; b < NB; b++) exp_bin[b] = 0;
        exp_total = 0; exp_ovf = 0; exp_lz = 0;
        @(negedge clk);
        layer_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (en) begin
            int cnt = 0;
            while (!s_ready) begin
                cnt++;
                @(negedge clk);
            end
            check(cnt == NB, "R3 clear cycles", cnt, NB);
        end
    endtask

    // Offer one token and wait for its acceptance; update the model (R1, R4, R5, R6).
    task automatic push(input logic [30:0] c, input logic [31:0] v, input bit lz, input bit last);
        s_token = {lz, c, v};
        s_last  = last;
        s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        if (c < NC && v < NV) begin
            exp_bin[int'(c) * NV + int'(v)]++;
            exp_total++;
        end else begin
            exp_ovf++;
        end
        if (lz) exp_lz++;
        if (last) begin
            check(s_ready == 1'b0, "R10 ready after last", s_ready, 0);
            s_token = {1'b0, 31'd0, 32'd1};
            s_last  = 1'b0;
        end
    endtask

    task automatic gap(input int n);
        s_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Collect the non-empty list until done; s_valid stays as the caller left it.
    task automatic collect(input bit dis);
        got_n = 0;
        while (!done) begin
            if (dis) check(s_ready == 1'b0, "R8 ready while disabled", s_ready, 0);
            if (ne_valid) begin
                if (got_n < NB) got_list[got_n] = int'(ne_ctx);
                got_n++;
            end
            @(negedge clk);
        end
        s_valid = 1'b0;
    endtask

    // Compare list, counters and every bin with the model.
    task automatic verify(input string tag);
        int k = 0;
        for (int c = 0; c < NC; c++) begin
            int sum = 0;
            for (int v = 0; v < NV; v++) sum += exp_bin[c * NV + v];
            if (sum > 0) begin
                check(k < got_n && got_list[k] == c, {"R7 list entry ", tag},
                      (k < got_n) ? got_list[k] : -1, c);
                k++;
            end
        end
        check(got_n == k, {"R7 list length ", tag}, got_n, k);
        check(total_cnt == CW'(exp_total), {"R5 total ", tag}, total_cnt, exp_total);
        check(ovf_cnt == CW'(exp_ovf), {"R4 overflow ", tag}, ovf_cnt, exp_ovf);
        check(lz_cnt == CW'(exp_lz), {"R6 lz count ", tag}, lz_cnt, exp_lz);
        for (int b = 0; b < NB; b++) begin
            rd_en = 1'b1; rd_ctx = 2'(b / NV); rd_val = 2'(b % NV);
            @(negedge clk);
            check(rd_valid === 1'b1 && rd_data == CW'(exp_bin[b]),
                  {"R1 R9 bin ", tag}, rd_valid ? rd_data : -1, exp_bin[b]);
        end
        rd_en = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R9 no read", rd_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state.
        check(s_ready == 0, "R11 ready", s_ready, 0);
        check(done == 0, "R11 done", done, 0);
        check(ne_valid == 0 && rd_valid == 0, "R11 strobes", ne_valid, 0);
        check(total_cnt == 0 && ovf_cnt == 0 && lz_cnt == 0, "R11 counters", total_cnt, 0);

        // Pass A: sweep all bins with varied counts, gaps and out-of-range words.
        begin_pass(1'b1);
        for (int c = 0; c < NC; c++) begin
            for (int v = 0; v < NV; v++) begin
                int n = (c == 2) ? 0 : ((c + v) % 3);
                for (int i = 0; i < n; i++) push(31'(c), 32'(v), v[0], 1'b0);
            end
            gap(c % 3);
        end
        push(31'd4, 32'd0, 1'b1, 1'b0);               // R4 context just past range
        push(31'd0, 32'd4, 1'b0, 1'b0);               // R4 value just past range
        push(31'h7FFF_FFFF, 32'd1, 1'b0, 1'b0);       // R4 top context
        push(31'd1, 32'hFFFF_FFFF, 1'b1, 1'b0);       // R4 top value
        push(31'd2, 32'd5, 1'b0, 1'b0);               // R4 must not mark context 2
        push(31'd3, 32'd3, 1'b0, 1'b1);
        collect(1'b0);
        verify("pass A");

        // Pass B: same-bin bursts and alternations (R2), flag-only difference (R6).
        begin_pass(1'b1);
        rd_en = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R9 read while counting", rd_valid, 0);
        rd_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            push(31'd1, 32'd2, 1'b0, 1'b0);
            push(31'd1, 32'd2, 1'b0, 1'b0);
            push(31'd1, 32'd3, 1'b0, 1'b0);
            push(31'd1, 32'd2, 1'b0, 1'b0);
            push(31'd0, 32'd0, 1'b1, 1'b0);
            push(31'd0, 32'd0, 1'b0, 1'b0);
        end
        push(31'd1, 32'd2, 1'b0, 1'b1);
        collect(1'b0);
        check(exp_bin[1 * NV + 2] == 61, "R2 model burst", exp_bin[1 * NV + 2], 61);
        verify("pass B");

        // Pass C: disabled layer with tokens offered throughout (R8).
        s_valid = 1'b1;
        s_token = {1'b1, 31'd1, 32'd1};
        s_last  = 1'b0;
        begin_pass(1'b0);
        collect(1'b1);
        verify("pass C R8");

        summary();
    end

endmodule